// File: doc/BRIEF.md
# Peripheral Bus Window Decoder

This block sits on a 32-bit internal peripheral bus. It decodes each request address and sends the access to one of five places. Three places are address windows. Each window removes its own base from the address and passes the request on to a legacy I/O space or a legacy memory space through a forwarding port. The firmware window is a second view of legacy memory. The other two places are register banks held inside the block. The interrupt-master bank holds a level-driven status register, its mask, a polarity register and a snapshot of the raw interrupt lines. The host-controller bank holds event-driven interrupt status and mask, serial-IRQ control, firmware read-size and segment-select settings, and the address of the last request that missed every decode range.

Every request gets exactly one response one clock later. A window access returns the read data and error flag that the forwarding port supplied in the request cycle. An access to a register bank completes locally. An address that matches nothing completes with an error response. Both status registers are cleared by writing ones. A hardware set that arrives in the same cycle as a clear takes precedence, so no event is lost.

Top module: `pbus_window_decoder`

## Requirements
- R1: Addresses 0xD001_0000 to 0xD001_FFFF go to the I/O window. The forwarding strobe is raised with win_space_o = 0 (I/O), and win_offset_o equals the address minus 0xD001_0000. Address 0xD002_0000 is outside this window.
- R2: Addresses from 0xE001_0000 up to 0xEFFF_FFFF go to the memory window. win_space_o = 1 (memory), and the offset equals the address minus 0xE001_0000.
- R3: Addresses 0xF000_0000 to 0xFFFF_FFFF go to the firmware window. win_space_o = 1, and the offset equals the address minus 0xF000_0000. The memory window also covers 0xF000_0000 to 0xF000_FFFF, and in that overlap the firmware window wins.
- R4: A request in cycle N produces rsp_valid_o in cycle N+1 and in no other cycle. For a window access, the response carries win_rdata_i as sampled in cycle N. If win_err_i was high in cycle N, the response has rsp_err_o = 1 and data 0xFFFF_FFFF.
- R5: An address outside all five ranges does not raise the forwarding strobe. It completes with rsp_err_o = 1 and data 0xFFFF_FFFF, and the host-controller error-address register (offset 0x40) takes that address.
- R6: A register-bank access must use size code 2. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Any other size gets an error response with data 0xFFFF_FFFF and changes no register.
- R7: Inside a bank, a read at an offset that holds no register returns 0xFFFF_FFFF without an error. A write to such an offset completes without an error and has no effect. The interrupt-master bank is based at 0xC001_0000 and is 0x2000 bytes long. The host-controller bank is based at 0xC001_2000 and is 0x1000 bytes long.
- R8: The firmware read-size register sits at host-controller offset 0x28 and resets to 0x0200_0000. Its bits 26:24 drive fw_rd_bytes_o as follows: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 4 gives 16 and code 7 gives 128. Any other code gives 4.
- R9: The serial-IRQ control register sits at host-controller offset 0x30 and resets to 0. Bit 31 drives serirq_en_o and bit 30 drives serirq_quiet_o. Bits 25:24 set serirq_start_clks_o: 0 gives 4, 1 gives 6, and 2 or 3 gives 8.
- R10: Writing a status register clears each bit that is 1 in the write data. The status registers are interrupt-master offset 0x50 and host-controller offset 0x38. The mask registers (0x54 and 0x34) and the polarity register (0x58) store the written value as it is.
- R11: When a hardware set and a clearing write reach the same host-controller status bit in the same cycle, the bit stays set.
- R12: The raw-input register (interrupt-master 0x5C) reads irq_lines_i as registered one clock earlier. Writes to it are ignored. Writes to the error-address register are also ignored.
- R13: An interrupt-master status bit is set in every cycle where the registered line XOR the polarity bit is 1. Each host-controller status bit is set by a pulse on hc_event_i. ims_irq_o and hc_irq_o are the OR of status AND mask for their bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Bus address |
| req_wdata_i | input | 32 | Write data |
| req_size_i | input | 2 | Access size code |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | 32 | Read data |
| win_valid_o | output | 1 | Forwarded window access |
| win_space_o | output | 1 | 0 = legacy I/O, 1 = legacy memory |
| win_write_o | output | 1 | Forwarded write flag |
| win_offset_o | output | 28 | Address minus the window base |
| win_wdata_o | output | 32 | Forwarded write data |
| win_size_o | output | 2 | Forwarded size code |
| win_rdata_i | input | 32 | Window read data, same cycle |
| win_err_i | input | 1 | Window error, same cycle |
| irq_lines_i | input | 32 | Raw interrupt-master lines |
| hc_event_i | input | 32 | Host-controller status set pulses |
| ims_irq_o | output | 1 | Interrupt-master interrupt |
| hc_irq_o | output | 1 | Host-controller interrupt |
| fw_rd_bytes_o | output | 8 | Decoded firmware read size in bytes |
| serirq_en_o | output | 1 | Serial-IRQ enable |
| serirq_quiet_o | output | 1 | Serial-IRQ quiet mode |
| serirq_start_clks_o | output | 4 | Start-frame width in clocks |

## Verification
The hardest case to reach is a clearing write that lands on a status bit in the same clock as a hardware set. The bench does this by raising hc_event_i at the same negative edge that presents the write-one-to-clear request. It then reads the register back to confirm that the contested bit survived and that its neighbour was cleared. The overlap between the memory and firmware windows is reached with an address just above 0xF000_0000, where an offset of 4 shows that the firmware window won. The level-driven interrupt-master status is reached by briefly writing the polarity register so that idle lines count as active, then restoring it before the status is read.

// File: rtl/pbus_dec_pkg.sv
package pbus_dec_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int WIN_OFF_W = 28;
  localparam int NUM_TGT   = 5;
  localparam int IMS_OFF_W = 13;
  localparam int HC_OFF_W  = 12;

  // index order is decode priority: lower index wins
  typedef enum logic [2:0] {
    TGT_IMS  = 3'd0,
    TGT_HC   = 3'd1,
    TGT_IO   = 3'd2,
    TGT_FW   = 3'd3,
    TGT_MEM  = 3'd4,
    TGT_NONE = 3'd7
  } tgt_e;

  localparam logic [ADDR_W-1:0] TGT_BASE [NUM_TGT] = '{
    32'hC001_0000, 32'hC001_2000, 32'hD001_0000, 32'hF000_0000, 32'hE001_0000};
  localparam logic [ADDR_W-1:0] TGT_SIZE [NUM_TGT] = '{
    32'h0000_2000, 32'h0000_1000, 32'h0001_0000, 32'h1000_0000, 32'h1000_0000};

  localparam logic [1:0] SZ_WORD = 2'd2;

  // interrupt-master bank offsets
  localparam int IMS_STAT = 'h50;
  localparam int IMS_MASK = 'h54;
  localparam int IMS_POL  = 'h58;
  localparam int IMS_RAW  = 'h5C;

  // host-controller bank offsets
  localparam int HC_SEG    = 'h24;
  localparam int HC_RDSZ   = 'h28;
  localparam int HC_SIRQ   = 'h30;
  localparam int HC_MASK   = 'h34;
  localparam int HC_STAT   = 'h38;
  localparam int HC_ERRADR = 'h40;

  localparam logic [DATA_W-1:0] RDSZ_RST = 32'h0200_0000;

  function automatic logic [7:0] rd_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd1;
      3'd1:    return 8'd2;
      3'd4:    return 8'd16;
      3'd7:    return 8'd128;
      default: return 8'd4;
    endcase
  endfunction

  function automatic logic [3:0] start_clks(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/pbus_addr_decode.sv
module pbus_addr_decode
  import pbus_dec_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = WIN_OFF_W
) (
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o,
  output logic [OW-1:0] off_o
);
  logic [NUM_TGT-1:0] hit;
  logic [AW-1:0]      diff [NUM_TGT];

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_rng
    assign diff[g] = addr_i - AW'(TGT_BASE[g]);
    assign hit[g]  = (addr_i >= AW'(TGT_BASE[g])) && (diff[g] < AW'(TGT_SIZE[g]));
  end

  always_comb begin
    tgt_o = TGT_NONE;
    off_o = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        tgt_o = tgt_e'(3'(i));
        off_o = diff[i][OW-1:0];
      end
    end
  end
endmodule

// File: rtl/pbus_ims_regs.sv
module pbus_ims_regs
  import pbus_dec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = IMS_OFF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] lines_i,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, mask_q, pol_q, raw_q;
  logic [DW-1:0] clr, set;

  assign set = raw_q ^ pol_q;
  assign clr = (wr_en_i && off_i == OW'(IMS_STAT)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      raw_q  <= '0;
    end else begin
      raw_q  <= lines_i;
      stat_q <= (stat_q & ~clr) | set;
      if (wr_en_i && off_i == OW'(IMS_MASK)) mask_q <= wdata_i;
      if (wr_en_i && off_i == OW'(IMS_POL))  pol_q  <= wdata_i;
    end
  end

  always_comb begin
    case (off_i)
      OW'(IMS_STAT): rdata_o = stat_q;
      OW'(IMS_MASK): rdata_o = mask_q;
      OW'(IMS_POL):  rdata_o = pol_q;
      OW'(IMS_RAW):  rdata_o = raw_q;
      default:       rdata_o = '1;
    endcase
  end

  assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/pbus_hc_regs.sv
module pbus_hc_regs
  import pbus_dec_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int OW = HC_OFF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] event_i,
  input  logic          err_cap_i,
  input  logic [AW-1:0] err_addr_i,
  output logic          irq_o,
  output logic [2:0]    rdsz_code_o,
  output logic          sirq_en_o,
  output logic          sirq_quiet_o,
  output logic [1:0]    sirq_start_o
);
  logic [DW-1:0] seg_q, rdsz_q, sirq_q, mask_q, stat_q;
  logic [AW-1:0] erradr_q;
  logic [DW-1:0] clr;

  assign clr = (wr_en_i && off_i == OW'(HC_STAT)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= '0;
      rdsz_q   <= RDSZ_RST;
      sirq_q   <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      erradr_q <= '0;
    end else begin
      // set after clear: a same-cycle event survives
      stat_q <= (stat_q & ~clr) | event_i;
      if (err_cap_i) erradr_q <= err_addr_i;
      if (wr_en_i) begin
        case (off_i)
          OW'(HC_SEG):  seg_q  <= wdata_i;
          OW'(HC_RDSZ): rdsz_q <= wdata_i;
          OW'(HC_SIRQ): sirq_q <= wdata_i;
          OW'(HC_MASK): mask_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off_i)
      OW'(HC_SEG):    rdata_o = seg_q;
      OW'(HC_RDSZ):   rdata_o = rdsz_q;
      OW'(HC_SIRQ):   rdata_o = sirq_q;
      OW'(HC_MASK):   rdata_o = mask_q;
      OW'(HC_STAT):   rdata_o = stat_q;
      OW'(HC_ERRADR): rdata_o = DW'(erradr_q);
      default:        rdata_o = '1;
    endcase
  end

  assign irq_o        = |(stat_q & mask_q);
  assign rdsz_code_o  = rdsz_q[26:24];
  assign sirq_en_o    = sirq_q[31];
  assign sirq_quiet_o = sirq_q[30];
  assign sirq_start_o = sirq_q[25:24];
endmodule

// File: rtl/pbus_window_decoder.sv
module pbus_window_decoder
  import pbus_dec_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int OW = WIN_OFF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_size_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          win_valid_o,
  output logic          win_space_o,
  output logic          win_write_o,
  output logic [OW-1:0] win_offset_o,
  output logic [DW-1:0] win_wdata_o,
  output logic [1:0]    win_size_o,
  input  logic [DW-1:0] win_rdata_i,
  input  logic          win_err_i,
  input  logic [DW-1:0] irq_lines_i,
  input  logic [DW-1:0] hc_event_i,
  output logic          ims_irq_o,
  output logic          hc_irq_o,
  output logic [7:0]    fw_rd_bytes_o,
  output logic          serirq_en_o,
  output logic          serirq_quiet_o,
  output logic [3:0]    serirq_start_clks_o
);
  tgt_e          tgt;
  logic [OW-1:0] off;
  logic          is_win, is_bank, size_ok;
  logic          ims_wr, hc_wr;
  logic [DW-1:0] ims_rdata, hc_rdata;
  logic [2:0]    rdsz_code;
  logic [1:0]    sirq_start;
  logic          rsp_err_d;
  logic [DW-1:0] rsp_rdata_d;
  logic          rsp_valid_q, rsp_err_q;
  logic [DW-1:0] rsp_rdata_q;

  pbus_addr_decode #(.AW(AW), .OW(OW)) u_dec (
    .addr_i (req_addr_i),
    .tgt_o  (tgt),
    .off_o  (off)
  );

  assign is_win  = (tgt == TGT_IO) || (tgt == TGT_FW) || (tgt == TGT_MEM);
  assign is_bank = (tgt == TGT_IMS) || (tgt == TGT_HC);
  assign size_ok = (req_size_i == SZ_WORD);

  assign ims_wr = req_valid_i && req_write_i && size_ok && (tgt == TGT_IMS);
  assign hc_wr  = req_valid_i && req_write_i && size_ok && (tgt == TGT_HC);

  pbus_ims_regs #(.DW(DW), .OW(IMS_OFF_W)) u_ims (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ims_wr),
    .off_i   (off[IMS_OFF_W-1:0]),
    .wdata_i (req_wdata_i),
    .rdata_o (ims_rdata),
    .lines_i (irq_lines_i),
    .irq_o   (ims_irq_o)
  );

  pbus_hc_regs #(.DW(DW), .AW(AW), .OW(HC_OFF_W)) u_hc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (hc_wr),
    .off_i        (off[HC_OFF_W-1:0]),
    .wdata_i      (req_wdata_i),
    .rdata_o      (hc_rdata),
    .event_i      (hc_event_i),
    .err_cap_i    (req_valid_i && (tgt == TGT_NONE)),
    .err_addr_i   (req_addr_i),
    .irq_o        (hc_irq_o),
    .rdsz_code_o  (rdsz_code),
    .sirq_en_o    (serirq_en_o),
    .sirq_quiet_o (serirq_quiet_o),
    .sirq_start_o (sirq_start)
  );

  assign fw_rd_bytes_o       = rd_bytes(rdsz_code);
  assign serirq_start_clks_o = start_clks(sirq_start);

  // window forwarding, combinational in the request cycle
  assign win_valid_o  = req_valid_i && is_win;
  assign win_space_o  = (tgt != TGT_IO);
  assign win_write_o  = req_write_i;
  assign win_offset_o = off;
  assign win_wdata_o  = req_wdata_i;
  assign win_size_o   = req_size_i;

  always_comb begin
    rsp_err_d   = 1'b1;
    rsp_rdata_d = '1;
    if (is_win) begin
      rsp_err_d   = win_err_i;
      rsp_rdata_d = win_err_i ? '1 : win_rdata_i;
    end else if (is_bank && size_ok) begin
      rsp_err_d   = 1'b0;
      rsp_rdata_d = (tgt == TGT_IMS) ? ims_rdata : hc_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) begin
        rsp_err_q   <= rsp_err_d;
        rsp_rdata_q <= rsp_rdata_d;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/pbus_window_decoder_chk.sv
module pbus_window_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic [1:0]  req_size_i,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [31:0] rsp_rdata_o,
  input logic        win_valid_o,
  input logic        win_space_o,
  input logic [27:0] win_offset_o,
  input logic [7:0]  fw_rd_bytes_o,
  input logic [3:0]  serirq_start_clks_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_rsp_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_rsp_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_err_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == 32'hFFFF_FFFF));

  assert_io_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_space_o) |-> (win_offset_o < 28'h001_0000));

  assert_rdbytes_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(fw_rd_bytes_o));

  assert_bad_size_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && req_valid_i && req_write_i && req_size_i != 2'd2) |=> $stable(fw_rd_bytes_o));

  assert_start_clks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serirq_start_clks_o == 4'd4) || (serirq_start_clks_o == 4'd6) || (serirq_start_clks_o == 4'd8));
endmodule

bind pbus_window_decoder pbus_window_decoder_chk u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .req_valid_i         (req_valid_i),
  .req_write_i         (req_write_i),
  .req_size_i          (req_size_i),
  .rsp_valid_o         (rsp_valid_o),
  .rsp_err_o           (rsp_err_o),
  .rsp_rdata_o         (rsp_rdata_o),
  .win_valid_o         (win_valid_o),
  .win_space_o         (win_space_o),
  .win_offset_o        (win_offset_o),
  .fw_rd_bytes_o       (fw_rd_bytes_o),
  .serirq_start_clks_o (serirq_start_clks_o)
);

// File: tb/pbus_window_decoder_tb.sv
`timescale 1ns/1ps
module pbus_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = 2'd2;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        win_valid, win_space, win_write;
  logic [27:0] win_offset;
  logic [31:0] win_wdata;
  logic [1:0]  win_size;
  logic [31:0] win_rdata;
  logic        win_err = 1'b0;
  logic [31:0] irq_lines = '0, hc_event = '0;
  logic        ims_irq, hc_irq;
  logic [7:0]  fw_rd_bytes;
  logic        serirq_en, serirq_quiet;
  logic [3:0]  serirq_clks;

  int n_chk = 0, n_bad = 0;
  logic        s_win, s_space;
  logic [27:0] s_off;

  always #10 clk = ~clk;

  // window responder: tags data with the space and the offset
  assign win_rdata = {3'b101, win_space, win_offset};

  pbus_window_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_size_i(req_size),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .win_valid_o(win_valid), .win_space_o(win_space), .win_write_o(win_write),
    .win_offset_o(win_offset), .win_wdata_o(win_wdata), .win_size_o(win_size),
    .win_rdata_i(win_rdata), .win_err_i(win_err),
    .irq_lines_i(irq_lines), .hc_event_i(hc_event),
    .ims_irq_o(ims_irq), .hc_irq_o(hc_irq), .fw_rd_bytes_o(fw_rd_bytes),
    .serirq_en_o(serirq_en), .serirq_quiet_o(serirq_quiet),
    .serirq_start_clks_o(serirq_clks)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  sz;
    logic        exp_err;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic        exp_win;
    logic        exp_space;
    logic [27:0] exp_off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'hC001_2028, 32'h0, 2'd2, 1'b0, 1'b1, 32'h0200_0000, 1'b0, 1'b0, 28'h0, 4'd8},  // R8 reset
    '{1'b1, 32'hC001_2028, 32'h0700_0000, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd8},  // R8
    '{1'b0, 32'hC001_2028, 32'h0, 2'd2, 1'b0, 1'b1, 32'h0700_0000, 1'b0, 1'b0, 28'h0, 4'd8},  // R8
    '{1'b0, 32'hC001_0000, 32'h0, 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 28'h0, 4'd7},  // R7
    '{1'b1, 32'hC001_2040, 32'h1234, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd12},      // R12
    '{1'b0, 32'hC001_2040, 32'h0, 2'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 28'h0, 4'd12},         // R12
    '{1'b0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 28'h0, 4'd5},  // R5
    '{1'b0, 32'hC001_2040, 32'h0, 2'd2, 1'b0, 1'b1, 32'h1000_0000, 1'b0, 1'b0, 28'h0, 4'd5},  // R5
    '{1'b1, 32'hC001_2028, 32'h0, 2'd1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd6},          // R6
    '{1'b0, 32'hC001_2028, 32'h0, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 28'h0, 4'd6},  // R6
    '{1'b0, 32'hC001_2028, 32'h0, 2'd2, 1'b0, 1'b1, 32'h0700_0000, 1'b0, 1'b0, 28'h0, 4'd6},  // R6
    '{1'b0, 32'hD001_0042, 32'h0, 2'd0, 1'b0, 1'b1, 32'hA000_0042, 1'b1, 1'b0, 28'h42, 4'd1},     // R1
    '{1'b0, 32'hD001_FFFF, 32'h0, 2'd0, 1'b0, 1'b1, 32'hA000_FFFF, 1'b1, 1'b0, 28'hFFFF, 4'd1},   // R1
    '{1'b0, 32'hD002_0000, 32'h0, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 28'h0, 4'd1},      // R1 edge
    '{1'b0, 32'hE001_1234, 32'h0, 2'd2, 1'b0, 1'b1, 32'hB000_1234, 1'b1, 1'b1, 28'h1234, 4'd2},   // R2
    '{1'b0, 32'hE001_0000, 32'h0, 2'd2, 1'b0, 1'b1, 32'hB000_0000, 1'b1, 1'b1, 28'h0, 4'd2},      // R2
    '{1'b0, 32'hF000_0004, 32'h0, 2'd2, 1'b0, 1'b1, 32'hB000_0004, 1'b1, 1'b1, 28'h4, 4'd3},      // R3 overlap
    '{1'b0, 32'hFFFF_FFFC, 32'h0, 2'd2, 1'b0, 1'b1, 32'hBFFF_FFFC, 1'b1, 1'b1, 28'hFFF_FFFC, 4'd3}, // R3
    '{1'b1, 32'hC001_0060, 32'h0, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd7},          // R7
    '{1'b1, 32'hC001_005C, 32'hFFFF, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd12},      // R12
    '{1'b0, 32'hC001_005C, 32'h0, 2'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 28'h0, 4'd12},         // R12
    '{1'b1, 32'hC001_0058, 32'hF, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd13},         // R13
    '{1'b1, 32'hC001_0058, 32'h0, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd13},         // R13
    '{1'b0, 32'hC001_0050, 32'h0, 2'd2, 1'b0, 1'b1, 32'hF, 1'b0, 1'b0, 28'h0, 4'd13},         // R13
    '{1'b1, 32'hC001_0050, 32'h5, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd10},         // R10
    '{1'b0, 32'hC001_0050, 32'h0, 2'd2, 1'b0, 1'b1, 32'hA, 1'b0, 1'b0, 28'h0, 4'd10},         // R10
    '{1'b1, 32'hC001_2034, 32'h8000_0001, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 28'h0, 4'd10}, // R10
    '{1'b0, 32'hC001_2034, 32'h0, 2'd2, 1'b0, 1'b1, 32'h8000_0001, 1'b0, 1'b0, 28'h0, 4'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    #2;
    s_win = win_valid; s_space = win_space; s_off = win_offset;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R4 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R8 reset bytes", 32'(fw_rd_bytes), 32'd4);
    check("R9 reset en", 32'(serirq_en), 32'd0);
    check("R13 reset hc_irq", 32'(hc_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset clks", 32'(serirq_clks), 32'd4);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].sz);
      check($sformatf("R%0d vec%0d rsp_valid", VEC[i].req, i), 32'(rsp_valid), 32'd1);
      check($sformatf("R%0d vec%0d err", VEC[i].req, i), 32'(rsp_err), 32'(VEC[i].exp_err));
      if (VEC[i].chk_rd)
        check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rsp_rdata, VEC[i].exp_rd);
      check($sformatf("R%0d vec%0d win_valid", VEC[i].req, i), 32'(s_win), 32'(VEC[i].exp_win));
      if (VEC[i].exp_win) begin
        check($sformatf("R%0d vec%0d space", VEC[i].req, i), 32'(s_space), 32'(VEC[i].exp_space));
        check($sformatf("R%0d vec%0d offset", VEC[i].req, i), 32'(s_off), 32'(VEC[i].exp_off));
      end
    end

    // R4: idle cycle drops rsp_valid
    @(negedge clk);
    check("R4 idle rsp_valid", 32'(rsp_valid), 32'd0);

    // R4: window error
    win_err = 1'b1;
    access(1'b0, 32'hE001_0008, 32'h0, 2'd2);
    win_err = 1'b0;
    check("R4 win err flag", 32'(rsp_err), 32'd1);
    check("R4 win err data", rsp_rdata, 32'hFFFF_FFFF);

    // R8 decode of read size
    check("R8 bytes 128", 32'(fw_rd_bytes), 32'd128);
    access(1'b1, 32'hC001_2028, 32'h0400_0000, 2'd2);
    check("R8 bytes 16", 32'(fw_rd_bytes), 32'd16);
    access(1'b1, 32'hC001_2028, 32'h0300_0000, 2'd2);
    check("R8 bytes other", 32'(fw_rd_bytes), 32'd4);

    // R9 serial IRQ fields
    access(1'b1, 32'hC001_2030, 32'hC100_0000, 2'd2);
    check("R9 en", 32'(serirq_en), 32'd1);
    check("R9 quiet", 32'(serirq_quiet), 32'd1);
    check("R9 clks 6", 32'(serirq_clks), 32'd6);
    access(1'b1, 32'hC001_2030, 32'h0200_0000, 2'd2);
    check("R9 clks 8", 32'(serirq_clks), 32'd8);
    check("R9 en off", 32'(serirq_en), 32'd0);

    // R11: set wins over same-cycle clear
    hc_event = 32'h3;
    @(negedge clk);
    hc_event = 32'h1;
    access(1'b1, 32'hC001_2038, 32'h3, 2'd2);
    hc_event = 32'h0;
    access(1'b0, 32'hC001_2038, 32'h0, 2'd2);
    check("R11 status after contested clear", rsp_rdata, 32'h1);
    check("R13 hc_irq masked on", 32'(hc_irq), 32'd1);
    access(1'b1, 32'hC001_2038, 32'h1, 2'd2);
    check("R10 hc_irq after clear", 32'(hc_irq), 32'd0);

    // R13 interrupt-master irq and raw lines
    check("R13 ims_irq mask 0", 32'(ims_irq), 32'd0);
    access(1'b1, 32'hC001_0054, 32'h2, 2'd2);
    check("R13 ims_irq mask 2", 32'(ims_irq), 32'd1);
    irq_lines = 32'h10;
    repeat (2) @(negedge clk);
    irq_lines = 32'h0;
    access(1'b0, 32'hC001_0050, 32'h0, 2'd2);
    check("R13 line sets status", rsp_rdata, 32'h1A);
    irq_lines = 32'h55;
    @(negedge clk);
    access(1'b0, 32'hC001_005C, 32'h0, 2'd2);
    check("R12 raw input", rsp_rdata, 32'h55);
    irq_lines = 32'h0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule